// File: doc/BRIEF.md
# UART Receive FIFO with Idle Timeout

This block is the receive buffer between a UART deserialiser and a CPU read port. Completed bytes from the shift register are written into a 16-byte first-in first-out store. The CPU pops them one at a time through a read strobe. The oldest byte is always presented on the read data output, so the CPU samples it in the same cycle as the strobe.

Two interrupt sources come out of the block. The data-available interrupt rises when the number of buffered bytes reaches a trigger level that software selects. The timeout interrupt handles the tail of a message, where fewer bytes than the trigger level arrive. It fires when bytes are waiting and there has been no read and no new byte for four character times. One character time is given as a programmable number of clock cycles.

When the store is full, a further incoming byte is discarded and a sticky overrun flag is raised. The flag stays set until a clear pulse arrives, which is sent when the status is read.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the level is 0, read data is 0, and `data_avail_irq`, `timeout_irq` and `overrun` are all low.
- R2: Bytes are returned in the order they were written, and up to 16 bytes are held. `level` always gives the number of bytes held.
- R3: A write while 16 bytes are held, with no read in the same cycle, is discarded. The level stays at 16, the stored bytes are unchanged, and `overrun` is set in the next cycle.
- R4: `overrun` stays set through reads and writes until a cycle in which `ovr_clr` is high. It is low after that cycle.
- R5: `data_avail_irq` is high exactly when `rx_int_en` is 1 and the level is at or above the trigger level. It falls in the cycle after a read takes the level below the trigger level.
- R6: `trig_sel` selects the trigger level: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R7: With `rx_int_en` high and at least one byte held, `timeout_irq` goes high after 4×`char_ticks` consecutive clock edges with no read and no stored write. The count starts after the last such access, and `char_ticks` must be at least 1. The interrupt never asserts while the FIFO is empty.
- R8: A read or a stored write clears `timeout_irq` in the next cycle and restarts the idle count from zero.
- R9: A read while the FIFO is empty returns 0 on `rd_data` and leaves the level unchanged. It also does not clear `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte from the shift register is valid this cycle |
| wr_data | input | 8 | Incoming byte |
| rd_en | input | 1 | CPU pops the oldest byte this cycle |
| rd_data | output | 8 | Oldest byte, or 0 when empty |
| trig_sel | input | 2 | Trigger level select (00:1, 01:4, 10:8, 11:14) |
| rx_int_en | input | 1 | Receive interrupt enable |
| char_ticks | input | 16 | Clock cycles per character time |
| ovr_clr | input | 1 | Clears the overrun flag |
| level | output | 5 | Number of bytes held |
| data_avail_irq | output | 1 | Trigger-level interrupt |
| timeout_irq | output | 1 | Idle timeout interrupt |
| overrun | output | 1 | Sticky overrun error flag |

## Verification
The ordering test fills the store with sixteen distinct bytes and drains it. This shows a pointer or wrap error as a wrong byte rather than as a wrong count. The same fill is then followed by an extra write, which separates a discarded byte from one that overwrote the head. The trigger test walks the level up to each of the four selected thresholds and back, one step at a time, so an off-by-one in the comparison shows up. The timeout tests sample one edge before and one edge at the expected expiry, after both writes and reads. This tells a correct restart apart from a count that carries over or that is never reset.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1);
  localparam int unsigned TICK_W = 16;
  localparam int unsigned IDLE_W = TICK_W + 2;

  // Map the two-bit select onto a byte count threshold.
  function automatic logic [LVL_W-1:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_level = LVL_W'(1);
      2'b01:   trig_level = LVL_W'(4);
      2'b10:   trig_level = LVL_W'(8);
      default: trig_level = LVL_W'(14);
    endcase
  endfunction

  // Four character times, in clock cycles.
  function automatic logic [IDLE_W-1:0] idle_limit(input logic [TICK_W-1:0] ticks);
    idle_limit = {2'b00, ticks} << 2;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned D = DEPTH,
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  input  logic             ovr_clr,
  output logic [W-1:0]     head_data,
  output logic [LVL_W-1:0] level,
  output logic             overrun,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam int unsigned AW = $clog2(D);

  logic [W-1:0]  mem [D];
  logic [AW-1:0] wptr, rptr;
  logic          empty, full, drop;

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(D));
  assign pop_ok  = rd_en && !empty;
  assign push_ok = wr_en && (!full || pop_ok);
  assign drop    = wr_en && !push_ok;
  assign head_data = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(D - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(D - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (ovr_clr)   overrun <= 1'b0;
      else if (drop) overrun <= 1'b1;
    end
  end

  always_comb begin
    p_no_overflow_r2: assert (level <= LVL_W'(D));
  end

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (level == LVL_W'(D)) && overrun);

  p_ovr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> (level == '0));
endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              has_data,
  input  logic              access,
  input  logic [TICK_W-1:0] char_ticks,
  output logic              expired
);
  logic [IDLE_W-1:0] idle_cnt;
  logic [IDLE_W-1:0] limit;

  assign limit = idle_limit(char_ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      expired  <= 1'b0;
    end else if (!has_data || access) begin
      idle_cnt <= '0;
      expired  <= 1'b0;
    end else if (!expired) begin
      if (idle_cnt == limit - 1'b1) expired  <= 1'b1;
      else                          idle_cnt <= idle_cnt + 1'b1;
    end
  end

  p_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> has_data);

  p_access_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> !expired);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic [1:0]        trig_sel,
  input  logic              rx_int_en,
  input  logic [TICK_W-1:0] char_ticks,
  input  logic              ovr_clr,
  output logic [LVL_W-1:0]  level,
  output logic              data_avail_irq,
  output logic              timeout_irq,
  output logic              overrun
);
  logic push_ok, pop_ok;
  logic fifo_access;
  logic idle_expired;
  logic at_trigger;

  rxf_store #(.D(DEPTH), .W(8)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .ovr_clr(ovr_clr),
    .head_data(rd_data), .level(level), .overrun(overrun),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  assign fifo_access = push_ok || pop_ok;

  rxf_idle_timer u_timer (
    .clk(clk), .rst_n(rst_n),
    .has_data(level != '0), .access(fifo_access),
    .char_ticks(char_ticks), .expired(idle_expired)
  );

  assign at_trigger     = (level >= trig_level(trig_sel));
  assign data_avail_irq = rx_int_en && at_trigger;
  assign timeout_irq    = rx_int_en && idle_expired;

  p_avail_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail_irq |-> (level != '0));

  p_empty_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (rd_data == 8'h00));
endmodule

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0, rx_int_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] trig_sel = 2'b00;
  logic [15:0] char_ticks = 16'd3;
  logic [4:0] level;
  logic       data_avail_irq, timeout_irq, overrun;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  uart_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .trig_sel(trig_sel),
    .rx_int_en(rx_int_en), .char_ticks(char_ticks), .ovr_clr(ovr_clr),
    .level(level), .data_avail_irq(data_avail_irq),
    .timeout_irq(timeout_irq), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_trig(input logic [1:0] s);
    int t[4] = '{1, 4, 8, 14};
    return t[s];
  endfunction

  task automatic push(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    d = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    logic [7:0] d;
    while (level != 0) pop(d);
  endtask

  task automatic t_reset();
    chk("R1", "level", level, 0);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "irqs+ovr", {data_avail_irq, timeout_irq, overrun}, 0);
  endtask

  task automatic t_order_overrun();
    logic [7:0] d;
    int bad = 0;
    for (int i = 0; i < 16; i++) push(8'(8'hA5 ^ (i * 37)));
    chk("R2", "level at 16", level, 16);
    chk("R3", "overrun before extra", overrun, 0);
    push(8'h77);
    chk("R3", "level after drop", level, 16);
    chk("R3", "overrun set", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      pop(d);
      if (d != 8'(8'hA5 ^ (i * 37))) bad++;
    end
    chk("R2", "order mismatches", bad, 0);
    chk("R2", "level drained", level, 0);
    chk("R4", "overrun held", overrun, 1);
    pop(d);
    chk("R9", "empty read data", d, 0);
    chk("R9", "empty read level", level, 0);
    chk("R9", "empty read keeps overrun", overrun, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk("R4", "overrun cleared", overrun, 0);
  endtask

  task automatic t_trigger();
    logic [7:0] d;
    rx_int_en = 1'b1;
    char_ticks = 16'd1000;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int i = 0; i < exp_trig(2'(s)) - 1; i++) push(8'(i));
      chk("R6", $sformatf("below trigger sel=%0d", s), data_avail_irq, 0);
      push(8'h55);
      chk("R6", $sformatf("at trigger sel=%0d", s), data_avail_irq, 1);
      push(8'h56);
      chk("R5", $sformatf("above trigger sel=%0d", s), data_avail_irq, 1);
      pop(d); pop(d);
      chk("R5", $sformatf("read below trigger sel=%0d", s), data_avail_irq, 0);
      push(8'h57);
      rx_int_en = 1'b0; #1;
      chk("R5", "gated by enable", data_avail_irq, 0);
      rx_int_en = 1'b1;
      drain();
    end
    char_ticks = 16'd3;
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    rx_int_en = 1'b1; trig_sel = 2'b11;
    idle(20);
    chk("R7", "no timeout when empty", timeout_irq, 0);
    push(8'h11);
    idle(11);
    chk("R7", "one edge before expiry", timeout_irq, 0);
    idle(1);
    chk("R7", "expired after 4 chars", timeout_irq, 1);
    push(8'h22);
    chk("R8", "write clears", timeout_irq, 0);
    idle(11);
    chk("R8", "restart after write, before", timeout_irq, 0);
    idle(1);
    chk("R8", "restart after write, expiry", timeout_irq, 1);
    pop(d);
    chk("R8", "read clears", timeout_irq, 0);
    chk("R2", "read byte", d, 8'h11);
    idle(11);
    chk("R8", "restart after read, before", timeout_irq, 0);
    idle(1);
    chk("R8", "restart after read, expiry", timeout_irq, 1);
    pop(d);
    idle(20);
    chk("R7", "cleared once empty", timeout_irq, 0);
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #5 t_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_overrun();
    t_trigger();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule